// File: doc/BRIEF.md
# PS/2 Host Transmit Channel with Supervisory Timeouts

This block sends one byte from a host controller to a PS/2 device. A write of a byte starts a frame when the channel is enabled, the direction control selects transmit, the transmitter is idle and no timeout is pending. The block first holds the clock line low for an inhibit period while it drives data low. It then releases the clock and follows the falling edges that the device drives on the clock line. It puts the eight data bits on the data line LSB first, then an odd parity bit. It releases the data line for the stop bit and for the device acknowledge.

Three watchdogs run on a 1 µs tick that is divided down from the system clock. They cover the wait for the first device edge, the gap between any two edges, and the span from the first edge to the parity edge. When a watchdog expires the frame is aborted and sticky flags are set. The clock line is then held low for at least a minimum hold time, and it is released only after the status has been read. The effective direction is forced to receive while the timeout flag stays set. An activity interrupt pulses each time the transmitter returns to idle.

The controller is one state machine. Its states are `S_IDLE` (idle), `S_REQ` (clock inhibit), `S_WAIT` (start bit driven, waiting for the first edge), `S_SHIFT` (data and parity), `S_ACK` (line released, waiting for the eleventh edge) and `S_HOLD` (timeout, clock held low). Its transitions are: IDLE→REQ on an accepted write. REQ→WAIT when the inhibit time ends. WAIT→SHIFT on the first fall. SHIFT→ACK on the tenth fall. ACK→IDLE on the eleventh fall. REQ/WAIT/SHIFT/ACK→HOLD on a watchdog expiry. REQ/WAIT/SHIFT/ACK→IDLE when the channel is disabled or the direction is cleared. HOLD→IDLE when the hold time has passed and a status read has been seen.

Top module: `ps2_host_tx`

## Requirements
- R1: After reset the transmitter is idle (`st_idle`=1), both flags are 0, both line drivers are off, no interrupt is pending, and `tx_dir_eff` follows `dir_tx`.
- R2: A byte write is accepted only when `en`=1, `dir_tx`=1, the transmitter is idle and the timeout flag is clear. An accepted write clears `st_idle` on the next cycle. A write made under any other condition leaves the lines and `st_idle` unchanged.
- R3: After an accepted write, the clock is held low (`ps2_clk_oe`=1) and data is driven low (`ps2_data_oe`=1) for INHIBIT_US ticks. The clock is then released while data stays low as the start bit.
- R4: A driver output of 1 pulls its line low. After device falls 1 to 8 the data line carries data bits 0 to 7 in that order. After fall 9 it carries odd parity, so the ten line values form an odd count of ones. After fall 10 the data line is released, giving a stop bit of 1.
- R5: On the eleventh fall the transmitter returns to idle with both lines released and no flag set.
- R6: If no first fall arrives within START_US ticks of the accepted write, both the start-timeout flag and the timeout flag are set.
- R7: If the gap between two successive falls after the first exceeds BIT_US ticks, the timeout flag alone is set.
- R8: If the span from fall 1 to fall 10 exceeds FRAME_US ticks, the timeout flag alone is set, even when every single gap is within BIT_US.
- R9: On a timeout the transmitter reports idle, releases data and holds the clock low. The clock is released only when at least HOLD_US ticks have passed and a status read has been seen while in the hold.
- R10: `tx_dir_eff` is 0 while the timeout flag is set, and equals `dir_tx` otherwise.
- R11: A clear strobe clears the timeout flag where mask bit 0 is 1 and the start-timeout flag where mask bit 1 is 1. A mask bit of 0 leaves its flag unchanged.
- R12: Clearing `en` or `dir_tx` during a frame returns the block to idle with both lines released and no flag set.
- R13: `irq_activity` is a one-cycle pulse on each 0-to-1 change of `st_idle`.
- R14: All watchdogs are disarmed while idle, so no flag is raised after a completed frame however long the block then stays idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Channel enable |
| dir_tx | input | 1 | Direction control, 1 = transmit |
| wr_tx | input | 1 | Transmit byte write strobe |
| wr_data | input | 8 | Byte to transmit |
| stat_rd | input | 1 | Status read strobe |
| stat_clr_wr | input | 1 | Status clear strobe |
| stat_clr_mask | input | 2 | Bit 0 clears timeout, bit 1 clears start timeout |
| ps2_clk_i | input | 1 | Sensed PS/2 clock line |
| ps2_clk_oe | output | 1 | 1 pulls the clock line low |
| ps2_data_oe | output | 1 | 1 pulls the data line low |
| tx_dir_eff | output | 1 | Effective direction after timeout forcing |
| st_idle | output | 1 | Transmitter idle status |
| st_timeout | output | 1 | Sticky transmit timeout flag |
| st_start_to | output | 1 | Sticky start-bit timeout flag |
| irq_activity | output | 1 | Pulse on idle rising |

## Verification
Normal frames are sent with bytes 0xA5, 0x00, 0xFF, 0x3C and 0x01. These patterns cover all-zero and all-one data, which flip the parity, alternating bits, which expose a wrong shift order, and a single set LSB. The timeout paths are reached with three device behaviours: a silent device, which should raise both flags; a device that stops after three clocks, which tests the gap watchdog; and a device with slow but legal gaps, which should raise only the timeout flag because the frame span is exceeded. Writes made while disabled, in receive direction or with a pending timeout, as well as aborts in mid-frame and clears with selective masks, show that each gating term and each flag acts on its own.

// File: rtl/ps2_tx_pkg.sv
package ps2_tx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REQ,
        S_WAIT,
        S_SHIFT,
        S_ACK,
        S_HOLD
    } tx_state_t;

    // fall count after which the next fall ends the driven part of the frame
    localparam logic [3:0] LAST_DRIVEN_FALL = 4'd9;

    function automatic logic odd_par(input logic [7:0] d);
        return ~^d;
    endfunction

endpackage

// File: rtl/ps2_us_tick.sv
module ps2_us_tick #(
    parameter int unsigned CLK_FREQ_MHZ = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned CW = (CLK_FREQ_MHZ > 1) ? $clog2(CLK_FREQ_MHZ) : 1;
    localparam logic [CW-1:0] TOP = CW'(CLK_FREQ_MHZ - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else begin
            tick_o <= (cnt_q == TOP);
            cnt_q  <= (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ps2_line_filter.sv
module ps2_line_filter #(
    parameter int unsigned FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic fall_o
);
    logic s1_q, s2_q, filt_q;
    logic [FILT_LEN-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q   <= 1'b1;
            s2_q   <= 1'b1;
            hist_q <= '1;
            filt_q <= 1'b1;
            fall_o <= 1'b0;
        end else begin
            s1_q   <= line_i;
            s2_q   <= s1_q;
            hist_q <= {hist_q[FILT_LEN-2:0], s2_q};
            fall_o <= filt_q && (hist_q == '0);
            if (hist_q == '1)
                filt_q <= 1'b1;
            else if (hist_q == '0)
                filt_q <= 1'b0;
        end
    end
endmodule

// File: rtl/ps2_span_timer.sv
module ps2_span_timer #(
    parameter int unsigned LIMIT = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic arm_i,
    input  logic restart_i,
    output logic expired_o
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!arm_i || restart_i)
            cnt_q <= '0;
        else if (tick_i && cnt_q != TOP)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired_o = arm_i && (cnt_q == TOP);

    assert_cnt_bound_R14: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_i |=> (cnt_q == '0));
endmodule

// File: rtl/ps2_host_tx.sv
module ps2_host_tx
    import ps2_tx_pkg::*;
#(
    parameter int unsigned CLK_FREQ_MHZ = 100,
    parameter int unsigned INHIBIT_US   = 100,
    parameter int unsigned START_US     = 25000,
    parameter int unsigned BIT_US       = 300,
    parameter int unsigned FRAME_US     = 2000,
    parameter int unsigned HOLD_US      = 300,
    parameter int unsigned FILT_LEN     = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       dir_tx,
    input  logic       wr_tx,
    input  logic [7:0] wr_data,
    input  logic       stat_rd,
    input  logic       stat_clr_wr,
    input  logic [1:0] stat_clr_mask,
    input  logic       ps2_clk_i,
    output logic       ps2_clk_oe,
    output logic       ps2_data_oe,
    output logic       tx_dir_eff,
    output logic       st_idle,
    output logic       st_timeout,
    output logic       st_start_to,
    output logic       irq_activity
);
    tx_state_t  state_q, state_d;
    logic [8:0] sh_q;
    logic [3:0] nfall_q;
    logic       tick, clk_fall;
    logic       inh_done, start_exp, bit_exp, frame_exp, hold_done;
    logic       rd_seen_q, idle_q;
    logic       wr_ok, abort, go_hold;

    ps2_us_tick #(.CLK_FREQ_MHZ(CLK_FREQ_MHZ)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick));

    ps2_line_filter #(.FILT_LEN(FILT_LEN)) u_clk_filt (
        .clk(clk), .rst_n(rst_n), .line_i(ps2_clk_i), .fall_o(clk_fall));

    ps2_span_timer #(.LIMIT(INHIBIT_US)) u_inh_tmr (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .arm_i(state_q == S_REQ), .restart_i(1'b0), .expired_o(inh_done));

    ps2_span_timer #(.LIMIT(START_US)) u_start_tmr (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .arm_i(state_q == S_REQ || state_q == S_WAIT), .restart_i(1'b0),
        .expired_o(start_exp));

    ps2_span_timer #(.LIMIT(BIT_US)) u_bit_tmr (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .arm_i(state_q == S_SHIFT || state_q == S_ACK), .restart_i(clk_fall),
        .expired_o(bit_exp));

    ps2_span_timer #(.LIMIT(FRAME_US)) u_frame_tmr (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .arm_i(state_q == S_SHIFT), .restart_i(1'b0), .expired_o(frame_exp));

    ps2_span_timer #(.LIMIT(HOLD_US)) u_hold_tmr (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .arm_i(state_q == S_HOLD), .restart_i(1'b0), .expired_o(hold_done));

    assign tx_dir_eff = dir_tx & ~st_timeout;
    assign wr_ok      = wr_tx && en && tx_dir_eff && (state_q == S_IDLE);
    assign abort      = !en || !dir_tx;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (wr_ok) state_d = S_REQ;
            S_REQ: begin
                if (abort)          state_d = S_IDLE;
                else if (start_exp) state_d = S_HOLD;
                else if (inh_done)  state_d = S_WAIT;
            end
            S_WAIT: begin
                if (abort)          state_d = S_IDLE;
                else if (start_exp) state_d = S_HOLD;
                else if (clk_fall)  state_d = S_SHIFT;
            end
            S_SHIFT: begin
                if (abort)                       state_d = S_IDLE;
                else if (bit_exp || frame_exp)   state_d = S_HOLD;
                else if (clk_fall && nfall_q == LAST_DRIVEN_FALL) state_d = S_ACK;
            end
            S_ACK: begin
                if (abort)         state_d = S_IDLE;
                else if (bit_exp)  state_d = S_HOLD;
                else if (clk_fall) state_d = S_IDLE;
            end
            S_HOLD:  if (hold_done && (rd_seen_q || stat_rd)) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    assign go_hold = (state_d == S_HOLD) && (state_q != S_HOLD);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // shift data and fall counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            nfall_q <= '0;
        end else if (wr_ok) begin
            sh_q    <= {odd_par(wr_data), wr_data};
            nfall_q <= '0;
        end else if (clk_fall && state_q == S_WAIT) begin
            nfall_q <= 4'd1;
        end else if (clk_fall && state_q == S_SHIFT) begin
            sh_q    <= {1'b1, sh_q[8:1]};
            nfall_q <= nfall_q + 1'b1;
        end
    end

    // sticky flags, read tracking, idle history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_timeout  <= 1'b0;
            st_start_to <= 1'b0;
            rd_seen_q   <= 1'b0;
            idle_q      <= 1'b1;
        end else begin
            idle_q <= st_idle;
            if (go_hold)
                st_timeout <= 1'b1;
            else if (stat_clr_wr && stat_clr_mask[0])
                st_timeout <= 1'b0;
            if (go_hold && start_exp)
                st_start_to <= 1'b1;
            else if (stat_clr_wr && stat_clr_mask[1])
                st_start_to <= 1'b0;
            if (state_q != S_HOLD)
                rd_seen_q <= 1'b0;
            else if (stat_rd)
                rd_seen_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        ps2_clk_oe  = 1'b0;
        ps2_data_oe = 1'b0;
        st_idle     = 1'b0;
        unique case (state_q)
            S_IDLE:  st_idle = 1'b1;
            S_REQ: begin
                ps2_clk_oe  = 1'b1;
                ps2_data_oe = 1'b1;
            end
            S_WAIT:  ps2_data_oe = 1'b1;
            S_SHIFT: ps2_data_oe = ~sh_q[0];
            S_ACK:   ps2_data_oe = 1'b0;
            S_HOLD: begin
                ps2_clk_oe = 1'b1;
                st_idle    = 1'b1;
            end
            default: st_idle = 1'b1;
        endcase
    end

    assign irq_activity = st_idle & ~idle_q;

    assert_start_sets_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_start_to) |-> st_timeout);

    assert_clk_low_on_timeout_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_timeout) |-> (ps2_clk_oe && st_idle && !ps2_data_oe));

    assert_hold_until_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HOLD && !rd_seen_q && !stat_rd) |=> ps2_clk_oe);

    assert_write_clears_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> !st_idle);

    assert_no_expiry_idle_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> !(start_exp || bit_exp || frame_exp));

    assert_irq_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
        irq_activity |=> !irq_activity);

    assert_ack_fall_idles_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ACK && clk_fall && en && dir_tx && !bit_exp) |=> (st_idle && !ps2_clk_oe));
endmodule

// File: tb/test_ps2_host_tx.sv
module test_ps2_host_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b1, dir_tx = 1'b1, wr_tx = 1'b0;
    logic [7:0] wr_data = '0;
    logic       stat_rd = 1'b0, stat_clr_wr = 1'b0;
    logic [1:0] stat_clr_mask = '0;
    logic       dev_clk = 1'b1, dev_data = 1'b1;
    logic       ps2_clk_oe, ps2_data_oe, tx_dir_eff, st_idle, st_timeout, st_start_to, irq_activity;
    logic       clk_line;

    always #2 clk = ~clk;
    assign clk_line = dev_clk & ~ps2_clk_oe;

    ps2_host_tx #(
        .CLK_FREQ_MHZ(4), .INHIBIT_US(25), .START_US(250), .BIT_US(30),
        .FRAME_US(200), .HOLD_US(30), .FILT_LEN(3)
    ) i_ps2_host_tx (
        .clk(clk), .rst_n(rst_n), .en(en), .dir_tx(dir_tx), .wr_tx(wr_tx),
        .wr_data(wr_data), .stat_rd(stat_rd), .stat_clr_wr(stat_clr_wr),
        .stat_clr_mask(stat_clr_mask), .ps2_clk_i(clk_line),
        .ps2_clk_oe(ps2_clk_oe), .ps2_data_oe(ps2_data_oe), .tx_dir_eff(tx_dir_eff),
        .st_idle(st_idle), .st_timeout(st_timeout), .st_start_to(st_start_to),
        .irq_activity(irq_activity));

    int errors = 0, checks = 0, irq_cnt = 0, i0;
    bit done = 0;
    logic [9:0] exp_q[$];
    logic [9:0] obs_q[$];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    always @(negedge clk) if (rst_n && irq_activity) irq_cnt++;

    // monitor: compare observed frames against expected
    always @(negedge clk) begin
        if (obs_q.size() > 0) begin
            logic [9:0] o;
            o = obs_q.pop_front();
            if (exp_q.size() == 0) chk("R4 unexpected frame", {22'd0, o}, 32'h3ff);
            else chk("R4 frame bits/parity/stop", {22'd0, o}, {22'd0, exp_q.pop_front()});
        end
    end

    task automatic send(input logic [7:0] b, input bit expect_frame);
        @(negedge clk);
        wr_tx = 1'b1; wr_data = b;
        if (expect_frame) exp_q.push_back({1'b1, ~^b, b});
        @(negedge clk);
        wr_tx = 1'b0;
    endtask

    task automatic device(input int half, input int nclk, input bit record);
        logic [9:0] bits = '0;
        int w = 0;
        while (!(ps2_clk_oe == 1'b0 && ps2_data_oe == 1'b1) && w < 2000) begin
            @(negedge clk); w++;
        end
        chk("R3 clock released with start bit", {31'd0, w < 2000}, 32'd1);
        repeat (10) @(negedge clk);
        for (int k = 0; k < nclk; k++) begin
            dev_clk = 1'b0;
            if (k == 10) dev_data = 1'b0;
            repeat (half) @(negedge clk);
            dev_clk = 1'b1;
            if (k < 10) bits[k] = ~ps2_data_oe;
            repeat (half) @(negedge clk);
        end
        dev_data = 1'b1;
        if (record && nclk == 11) obs_q.push_back(bits);
    endtask

    task automatic read_status();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic clear(input logic [1:0] m);
        @(negedge clk); stat_clr_wr = 1'b1; stat_clr_mask = m;
        @(negedge clk); stat_clr_wr = 1'b0; stat_clr_mask = '0;
    endtask

    task automatic good_frame(input logic [7:0] b);
        send(b, 1);
        repeat (2) @(negedge clk);
        chk("R2 idle cleared by write", {31'd0, st_idle}, 32'd0);
        chk("R3 clock inhibit", {31'd0, ps2_clk_oe}, 32'd1);
        chk("R3 data low in inhibit", {31'd0, ps2_data_oe}, 32'd1);
        i0 = irq_cnt;
        device(20, 11, 1);
        repeat (5) @(negedge clk);
        chk("R5 idle after frame", {31'd0, st_idle}, 32'd1);
        chk("R5 lines released", {30'd0, ps2_clk_oe, ps2_data_oe}, 32'd0);
        chk("R5 no timeout", {30'd0, st_timeout, st_start_to}, 32'd0);
        chk("R13 one irq per frame", irq_cnt - i0, 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset idle", {31'd0, st_idle}, 32'd1);
        chk("R1 reset flags", {30'd0, st_timeout, st_start_to}, 32'd0);
        chk("R1 reset lines", {30'd0, ps2_clk_oe, ps2_data_oe}, 32'd0);
        chk("R1 reset irq", {31'd0, irq_activity}, 32'd0);
        chk("R1 dir follows", {31'd0, tx_dir_eff}, 32'd1);

        good_frame(8'hA5);
        good_frame(8'h00);
        good_frame(8'hFF);
        good_frame(8'h3C);
        good_frame(8'h01);

        // R14: long idle after a frame raises nothing
        repeat (1200) @(negedge clk);
        chk("R14 no timeout while idle", {30'd0, st_timeout, st_start_to}, 32'd0);

        // R2: ignored writes
        en = 1'b0;
        send(8'h55, 0);
        repeat (3) @(negedge clk);
        chk("R2 write ignored when disabled", {30'd0, st_idle, ps2_clk_oe}, 32'd2);
        en = 1'b1; dir_tx = 1'b0;
        send(8'h55, 0);
        repeat (3) @(negedge clk);
        chk("R2 write ignored in receive", {30'd0, st_idle, ps2_clk_oe}, 32'd2);
        chk("R10 dir follows dir_tx", {31'd0, tx_dir_eff}, 32'd0);
        dir_tx = 1'b1;

        // R6: silent device
        i0 = irq_cnt;
        send(8'h12, 0);
        repeat (1100) @(negedge clk);
        chk("R6 start timeout flag", {31'd0, st_start_to}, 32'd1);
        chk("R6 timeout flag", {31'd0, st_timeout}, 32'd1);
        chk("R9 clock held, data released", {30'd0, ps2_clk_oe, ps2_data_oe}, 32'd2);
        chk("R9 idle on timeout", {31'd0, st_idle}, 32'd1);
        chk("R13 irq on timeout", irq_cnt - i0, 32'd1);
        chk("R10 direction forced", {31'd0, tx_dir_eff}, 32'd0);
        repeat (200) @(negedge clk);
        chk("R9 clock held until read", {31'd0, ps2_clk_oe}, 32'd1);
        read_status();
        repeat (3) @(negedge clk);
        chk("R9 clock released after read", {31'd0, ps2_clk_oe}, 32'd0);
        send(8'h77, 0);
        repeat (3) @(negedge clk);
        chk("R2 write ignored with timeout pending", {30'd0, st_idle, ps2_clk_oe}, 32'd2);

        // R11: selective clears
        clear(2'b00);
        chk("R11 zero mask keeps flags", {30'd0, st_timeout, st_start_to}, 32'd3);
        clear(2'b10);
        chk("R11 clear start only", {30'd0, st_timeout, st_start_to}, 32'd2);
        clear(2'b01);
        chk("R11 clear timeout", {30'd0, st_timeout, st_start_to}, 32'd0);
        chk("R10 direction restored", {31'd0, tx_dir_eff}, 32'd1);

        // R7: device stops after three clocks
        send(8'hC3, 0);
        device(20, 3, 0);
        begin
            int w = 0;
            while (!st_timeout && w < 400) begin @(negedge clk); w++; end
        end
        chk("R7 gap timeout flag", {31'd0, st_timeout}, 32'd1);
        chk("R7 no start flag", {31'd0, st_start_to}, 32'd0);
        read_status();
        repeat (10) @(negedge clk);
        chk("R9 minimum hold after early read", {31'd0, ps2_clk_oe}, 32'd1);
        repeat (150) @(negedge clk);
        chk("R9 released after hold", {31'd0, ps2_clk_oe}, 32'd0);
        clear(2'b11);

        // R8: slow but legal gaps, frame span too long
        send(8'h5A, 0);
        device(52, 11, 0);
        chk("R8 span timeout flag", {31'd0, st_timeout}, 32'd1);
        chk("R8 no start flag", {31'd0, st_start_to}, 32'd0);
        chk("R9 still held without read", {31'd0, ps2_clk_oe}, 32'd1);
        read_status();
        repeat (3) @(negedge clk);
        chk("R9 released after read", {31'd0, ps2_clk_oe}, 32'd0);
        clear(2'b11);

        // R12: aborts
        send(8'h99, 0);
        device(20, 4, 0);
        dir_tx = 1'b0;
        repeat (2) @(negedge clk);
        chk("R12 abort by direction", {28'd0, st_idle, ps2_clk_oe, ps2_data_oe, st_timeout}, 32'h8);
        dir_tx = 1'b1;
        send(8'h66, 0);
        device(20, 2, 0);
        en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R12 abort by enable", {28'd0, st_idle, ps2_clk_oe, ps2_data_oe, st_timeout}, 32'h8);
        en = 1'b1;

        good_frame(8'h81);
        repeat (5) @(negedge clk);
        chk("R4 all frames compared", exp_q.size(), 32'd0);
        finish_run();
    end
endmodule